// File: doc/BRIEF.md
# Sleep Wake Source Controller

This block holds the device's low-power state and decides, for each depth of sleep, which events are allowed to bring it back to full operation. The processor asks for a sleep depth with a one-cycle request. From then on the block watches a dedicated wake pin, a watchdog expiry strobe and a bank of general-purpose input lines. Which of these may end the sleep depends on the depth. When a permitted source fires, the block emits a single-cycle wake pulse, returns its mode output to active, and records the responsible sources in a sticky cause register. That register stays set until the processor clears it.

The wake pin and the general-purpose lines are asynchronous, so each passes through two synchroniser flops before any level test. Each line has its own polarity, its own wake enable and its own interrupt enable, all loaded together by one configuration strobe. Interrupt outputs follow the line levels in every mode. Wake decisions use the wake enables only. If a sleep request arrives while a source it would accept is already active, the block does not enter that state at all: it wakes on the spot.

Top module: `wake_ctrl`

## Requirements
- R1: After reset the mode is active (code 0), the wake pulse is low, the cause register is zero, and all wake enables, interrupt enables and polarity bits are cleared, so an asserted line drives no interrupt.
- R2: Mode codes are 0 active, 1 deep sleep, 2 hibernate, 3 dormant. A sleep request is taken only in active mode and moves the mode to the requested code on the next clock edge. A request made while asleep, or one that names code 0, has no effect.
- R3: In dormant mode (3) only the wake pin ends the sleep. Watchdog strobes and lines are ignored even when their wake enables are set.
- R4: In hibernate mode (2) either the wake pin or a watchdog strobe ends the sleep. Lines are ignored.
- R5: In deep sleep mode (1) only a line whose wake enable is set ends the sleep. The wake pin, the watchdog and lines without a wake enable are ignored.
- R6: A line is active when its synchronised level XOR its polarity bit is 1, so polarity 1 makes a low level the active one. The wake pin is active high.
- R7: A pin or line change is seen three clock edges after it is driven (two synchroniser edges, then one register edge). The watchdog strobe is seen on the first edge. A wake produces a wake pulse exactly one cycle long, and the mode is 0 in that same cycle.
- R8: Cause bits: bit 0 is the wake pin, bit 1 is the watchdog, and bit 2+i is line i. A wake ORs the sources that caused it into the register. Bits persist across later wakes until a one-cycle clear strobe zeroes the register on the next edge.
- R9: Interrupt output i is high when line i is active and its interrupt enable is set, whatever the mode and whatever the wake enable. It lags the line input by two edges.
- R10: A sleep request made while a source that the requested mode would accept is already active keeps the mode at 0. The wake pulse and the cause bit appear on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wakePinIn | input | 1 | Dedicated wake pin, asynchronous |
| wdtExpire | input | 1 | Watchdog expiry strobe, synchronous |
| lineIn | input | NUM_LINES | General-purpose input lines, asynchronous |
| cfgWrite | input | 1 | Loads the three configuration vectors |
| cfgWakeEn | input | NUM_LINES | Per-line wake enable |
| cfgIrqEn | input | NUM_LINES | Per-line interrupt enable |
| cfgPol | input | NUM_LINES | Per-line polarity, 1 means active low |
| sleepReq | input | 1 | One-cycle sleep request |
| reqMode | input | 2 | Requested mode code |
| causeClr | input | 1 | Clears the cause register |
| curMode | output | 2 | Current mode code |
| wakePulse | output | 1 | One-cycle wake indication |
| wakeCause | output | NUM_LINES+2 | Sticky wake cause |
| irqOut | output | NUM_LINES | Per-line interrupt levels |

## Verification
The bench targets mode-dependent filtering. It raises every source that each depth must ignore, such as a watchdog strobe while dormant or the wake pin during deep sleep. A mask that is wrong for one mode would leave the sleep early and set a stray cause bit. The bench times the wake pulse against the synchroniser latency and checks that it lasts one cycle. A design with one synchroniser stage too many or too few would shift the pulse or stretch it. Inverted polarity, interrupts with wake disabled, causes that build up across two wakes without a clear, and a request that meets an already active source all show up as wrong mode codes, a missing pulse or wrong cause bits.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_DEEP   = 2'd1,
    MODE_HIB    = 2'd2,
    MODE_DORM   = 2'd3
  } mode_t;

  typedef struct packed {
    logic capture;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wakePinIn,
  input  logic                 wdtExpire,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 cfgWrite,
  input  logic [NUM_LINES-1:0] cfgWakeEn,
  input  logic [NUM_LINES-1:0] cfgIrqEn,
  input  logic [NUM_LINES-1:0] cfgPol,
  input  mode_t                evalMode,
  input  strobe_t              strb,
  output logic                 anyHit,
  output logic [NUM_LINES+1:0] wakeCause,
  output logic [NUM_LINES-1:0] irqOut
);
  localparam int SRC_W  = NUM_LINES + 2;
  localparam int SYNC_W = NUM_LINES + 1;

  logic [SYNC_W-1:0]    syncA, syncB;
  logic [NUM_LINES-1:0] wakeEn, irqEn, pol, lineAct;
  logic [SRC_W-1:0]     srcActive, modeMask, hitVec, causeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {lineIn, wakePinIn};
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn <= '0;
      irqEn  <= '0;
      pol    <= '0;
    end else if (cfgWrite) begin
      wakeEn <= cfgWakeEn;
      irqEn  <= cfgIrqEn;
      pol    <= cfgPol;
    end
  end

  assign lineAct   = syncB[SYNC_W-1:1] ^ pol;
  assign srcActive = {lineAct & wakeEn, wdtExpire, syncB[0]};
  assign irqOut    = lineAct & irqEn;

  always_comb begin
    unique case (evalMode)
      MODE_DORM: modeMask = {{NUM_LINES{1'b0}}, 2'b01};
      MODE_HIB:  modeMask = {{NUM_LINES{1'b0}}, 2'b11};
      MODE_DEEP: modeMask = {{NUM_LINES{1'b1}}, 2'b00};
      default:   modeMask = '0;
    endcase
  end

  assign hitVec = srcActive & modeMask;
  assign anyHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeQ <= '0;
    else       causeQ <= (strb.clear ? '0 : causeQ) | (strb.capture ? hitVec : '0);
  end

  assign wakeCause = causeQ;

  // R8: without a clear strobe no cause bit is ever lost
  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> ((causeQ & $past(causeQ)) == $past(causeQ)));

  // R1: enables hold between configuration writes
  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> ($stable(wakeEn) && $stable(irqEn) && $stable(pol)));
endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sleepReq,
  input  mode_t   reqMode,
  input  logic    causeClr,
  input  logic    anyHit,
  output mode_t   evalMode,
  output mode_t   curMode,
  output logic    wakePulse,
  output strobe_t strb
);
  mode_t modeQ, modeNext;
  logic  pulseNext;

  always_comb begin
    if (modeQ != MODE_ACTIVE) evalMode = modeQ;
    else if (sleepReq)        evalMode = reqMode;
    else                      evalMode = MODE_ACTIVE;
  end

  always_comb begin
    modeNext  = modeQ;
    pulseNext = 1'b0;
    if (modeQ != MODE_ACTIVE) begin
      if (anyHit) begin
        modeNext  = MODE_ACTIVE;
        pulseNext = 1'b1;
      end
    end else if (sleepReq && reqMode != MODE_ACTIVE) begin
      if (anyHit) pulseNext = 1'b1;
      else        modeNext  = reqMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_ACTIVE;
      wakePulse <= 1'b0;
    end else begin
      modeQ     <= modeNext;
      wakePulse <= pulseNext;
    end
  end

  assign curMode      = modeQ;
  assign strb.capture = anyHit;
  assign strb.clear   = causeClr;

  // R7: a wake pulse always coincides with the active mode
  assert_pulse_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (modeQ == MODE_ACTIVE));

  // R2: while asleep and with no permitted source, the mode holds
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_ACTIVE && !anyHit) |=> (modeQ == $past(modeQ)));
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wakePinIn,
  input  logic                 wdtExpire,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 cfgWrite,
  input  logic [NUM_LINES-1:0] cfgWakeEn,
  input  logic [NUM_LINES-1:0] cfgIrqEn,
  input  logic [NUM_LINES-1:0] cfgPol,
  input  logic                 sleepReq,
  input  logic [1:0]           reqMode,
  input  logic                 causeClr,
  output logic [1:0]           curMode,
  output logic                 wakePulse,
  output logic [NUM_LINES+1:0] wakeCause,
  output logic [NUM_LINES-1:0] irqOut
);
  mode_t   evalMode, modeQ;
  strobe_t strb;
  logic    anyHit;

  wake_control u_control (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .reqMode(mode_t'(reqMode)),
    .causeClr(causeClr), .anyHit(anyHit), .evalMode(evalMode),
    .curMode(modeQ), .wakePulse(wakePulse), .strb(strb)
  );

  wake_datapath #(.NUM_LINES(NUM_LINES)) u_datapath (
    .clk(clk), .rstN(rstN), .wakePinIn(wakePinIn), .wdtExpire(wdtExpire),
    .lineIn(lineIn), .cfgWrite(cfgWrite), .cfgWakeEn(cfgWakeEn),
    .cfgIrqEn(cfgIrqEn), .cfgPol(cfgPol), .evalMode(evalMode), .strb(strb),
    .anyHit(anyHit), .wakeCause(wakeCause), .irqOut(irqOut)
  );

  assign curMode = modeQ;

  // R3: leaving dormant always leaves the pin cause bit set
  assert_dormant_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curMode) == 2'd3 && curMode != 2'd3) |-> wakeCause[0]);

  // R4: leaving hibernate always leaves a pin or watchdog cause bit set
  assert_hib_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curMode) == 2'd2 && curMode != 2'd2) |-> (wakeCause[1:0] != 2'b00));
endmodule

// File: tb/wake_ctrl_bench.sv
module wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakePinIn = 1'b0, wdtExpire = 1'b0, cfgWrite = 1'b0;
  logic [N-1:0] lineIn = '0, cfgWakeEn = '0, cfgIrqEn = '0, cfgPol = '0;
  logic sleepReq = 1'b0, causeClr = 1'b0;
  logic [1:0] reqMode = 2'd0;
  logic [1:0] curMode;
  logic wakePulse;
  logic [N+1:0] wakeCause;
  logic [N-1:0] irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_ctrl #(.NUM_LINES(N)) u_wake_ctrl (
    .clk(clk), .rstN(rstN), .wakePinIn(wakePinIn), .wdtExpire(wdtExpire),
    .lineIn(lineIn), .cfgWrite(cfgWrite), .cfgWakeEn(cfgWakeEn),
    .cfgIrqEn(cfgIrqEn), .cfgPol(cfgPol), .sleepReq(sleepReq),
    .reqMode(reqMode), .causeClr(causeClr), .curMode(curMode),
    .wakePulse(wakePulse), .wakeCause(wakeCause), .irqOut(irqOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic configure(input logic [N-1:0] we, input logic [N-1:0] ie,
                           input logic [N-1:0] po);
    cfgWakeEn = we; cfgIrqEn = ie; cfgPol = po; cfgWrite = 1'b1;
    tick(1);
    cfgWrite = 1'b0;
  endtask

  task automatic enterSleep(input logic [1:0] m);
    sleepReq = 1'b1; reqMode = m;
    tick(1);
    sleepReq = 1'b0; reqMode = 2'd0;
  endtask

  task automatic clearCause();
    causeClr = 1'b1;
    tick(1);
    causeClr = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "mode", curMode, 0);
    chk("R1", "pulse", wakePulse, 0);
    chk("R1", "cause", wakeCause, 0);
    lineIn[0] = 1'b1;
    tick(3);
    chk("R1", "irq with cleared enables", irqOut, 0);
    enterSleep(2'd0);
    chk("R2", "request of code 0 ignored", curMode, 0);
    chk("R2", "no pulse for code 0", wakePulse, 0);
    lineIn[0] = 1'b0;
    tick(3);
  endtask

  task automatic testDormant();
    configure('1, '0, '0);
    enterSleep(2'd3);
    chk("R2", "enter dormant", curMode, 3);
    wdtExpire = 1'b1; tick(1); wdtExpire = 1'b0;
    chk("R3", "watchdog ignored", curMode, 3);
    lineIn[2] = 1'b1; tick(3);
    chk("R3", "enabled line ignored", curMode, 3);
    lineIn[2] = 1'b0; tick(3);
    wakePinIn = 1'b1; tick(2);
    chk("R7", "no wake before third edge", curMode, 3);
    tick(1);
    chk("R3", "pin wakes dormant", curMode, 0);
    chk("R7", "pulse on third edge", wakePulse, 1);
    chk("R8", "pin cause bit0", wakeCause, 14'h0001);
    tick(1);
    chk("R7", "pulse lasts one cycle", wakePulse, 0);
    wakePinIn = 1'b0; tick(3);
    clearCause();
    chk("R8", "clear zeroes cause", wakeCause, 0);
  endtask

  task automatic testHibernate();
    configure('1, '0, '0);
    enterSleep(2'd2);
    chk("R2", "enter hibernate", curMode, 2);
    enterSleep(2'd3);
    chk("R2", "request while asleep ignored", curMode, 2);
    lineIn[4] = 1'b1; tick(3);
    chk("R4", "line ignored in hibernate", curMode, 2);
    lineIn[4] = 1'b0; tick(3);
    wdtExpire = 1'b1; tick(1); wdtExpire = 1'b0;
    chk("R4", "watchdog wakes hibernate", curMode, 0);
    chk("R7", "watchdog pulse", wakePulse, 1);
    chk("R8", "watchdog cause bit1", wakeCause, 14'h0002);
    enterSleep(2'd2);
    wakePinIn = 1'b1; tick(3);
    chk("R4", "pin wakes hibernate", curMode, 0);
    chk("R8", "causes accumulate", wakeCause, 14'h0003);
    wakePinIn = 1'b0; tick(3);
    clearCause();
  endtask

  task automatic testDeep();
    configure(12'h020, '0, '0);
    enterSleep(2'd1);
    chk("R2", "enter deep sleep", curMode, 1);
    wakePinIn = 1'b1; tick(3);
    chk("R5", "pin ignored in deep", curMode, 1);
    wakePinIn = 1'b0; tick(3);
    wdtExpire = 1'b1; tick(1); wdtExpire = 1'b0;
    chk("R5", "watchdog ignored in deep", curMode, 1);
    lineIn[3] = 1'b1; tick(3);
    chk("R5", "disabled line ignored", curMode, 1);
    chk("R5", "no pulse while ignored", wakePulse, 0);
    lineIn[3] = 1'b0;
    lineIn[5] = 1'b1; tick(3);
    chk("R5", "enabled line wakes", curMode, 0);
    chk("R8", "line5 cause bit7", wakeCause, 14'h0080);
    lineIn[5] = 1'b0; tick(3);
    clearCause();
  endtask

  task automatic testPolarity();
    lineIn[7] = 1'b1; tick(3);
    configure(12'h080, '0, 12'h080);
    enterSleep(2'd1);
    chk("R6", "high level inactive with polarity 1", curMode, 1);
    lineIn[7] = 1'b0; tick(3);
    chk("R6", "low level wakes with polarity 1", curMode, 0);
    chk("R6", "line7 cause bit9", wakeCause, 14'h0200);
    configure('0, '0, '0);
    clearCause();
  endtask

  task automatic testImmediate();
    configure(12'h001, '0, '0);
    lineIn[0] = 1'b1; tick(3);
    enterSleep(2'd1);
    chk("R10", "mode stays active", curMode, 0);
    chk("R10", "pulse at request", wakePulse, 1);
    chk("R10", "cause line0 bit2", wakeCause, 14'h0004);
    lineIn[0] = 1'b0; tick(3);
    clearCause();
  endtask

  task automatic testIrq();
    configure('0, 12'h010, '0);
    lineIn[4] = 1'b1; tick(2);
    chk("R9", "irq on enabled line", irqOut, 12'h010);
    lineIn[6] = 1'b1; tick(2);
    chk("R9", "no irq on disabled line", irqOut, 12'h010);
    enterSleep(2'd3);
    tick(1);
    chk("R9", "irq kept while dormant", irqOut, 12'h010);
    chk("R9", "irq line does not wake", curMode, 3);
    wakePinIn = 1'b1; tick(3);
    chk("R3", "pin exits after irq test", curMode, 0);
    wakePinIn = 1'b0; lineIn = '0; tick(3);
    chk("R9", "irq drops with line", irqOut, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testDormant();
    testHibernate();
    testDeep();
    testPolarity();
    testImmediate();
    testIrq();
    finished = 1;
    summary();
  end
endmodule